// File: doc/BRIEF.md
# Serial Receiver with Deferred Overrun Reporting

This block turns an asynchronous serial line into bytes for a processor. It watches a synchronized receive line, clocked by a sixteen-times oversample tick supplied from outside. It takes in eight data bits, least significant bit first, and then one or two stop bits, the count chosen by a configuration input. Each finished character is placed in a data register, and a status byte reports whether data is waiting and whether a framing, break or overrun condition was seen. An interrupt output tells software that a character or an error needs attention.

Overrun is reported in a deferred way. When a character completes while the previous one is still unread, the held byte is kept and the newcomer is dropped. The overrun and break flags stay hidden until software has read the good byte. That data read then reveals them. Software then reads the status once, and a final data read clears the error state. Read strobes are single-cycle pulses. The data and status outputs always show the current register contents.

Top module: `rx_deferred_top`

## Requirements
- R1: After a synchronous reset, the data output is 0x00, the status output is 0x00 and the interrupt is low.
- R2: A well-formed character appears on the data output with its bits taken least significant first. Status bit 7 (data available) is set and the interrupt goes high.
- R3: With no overrun pending or visible, a data read clears status bit 7, bit 3 and bit 0, and drops the interrupt.
- R4: A first stop bit sampled low sets status bit 0 (framing error) and raises the interrupt. A data read clears both.
- R5: In two-stop-bit mode, a low second stop bit is ignored: no framing error is reported.
- R6: A character that completes while a byte is unread does not change the data output. It does not make status bit 1 (overrun) or bit 3 (break) visible.
- R7: A data read taken while an overrun is hidden makes status bit 1 visible and keeps bit 7 set. It leaves the data output unchanged and holds the interrupt high.
- R8: If the dropped character was a break, the data read in R7 also sets status bit 3.
- R9: A status read that shows bit 1, followed by a data read, clears status bits 7, 3, 1 and 0 and the interrupt. The data output then changes only when the next character completes.
- R10: A data read taken while overrun is visible, with no status read since it appeared, leaves status bits 7 and 1 set.
- R11: Data bits and first stop bit all low form a break. The result is data 0x00 with status bits 3 and 0 set. No new character starts until the line has returned high.
- R12: A low pulse shorter than half a bit, checked at the centre of the start bit, produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| two_stop | input | 1 | 1 selects two stop bits |
| rd_data | input | 1 | Read strobe for the data register |
| rd_stat | input | 1 | Read strobe for the status register |
| data_out | output | 8 | Receive data register |
| status_out | output | 8 | Status: bit 7 available, bit 3 break, bit 1 overrun, bit 0 framing |
| irq | output | 1 | Receive interrupt |

## Verification
The assertions assume the two read strobes are single-cycle pulses that never coincide with a character completing. They also assume the oversample tick arrives at a steady rate, so that a bit lasts sixteen ticks. The bench keeps within these limits. It issues reads only between frames, after each stop bit has been sampled. It drives every bit for exactly sixteen tick periods, and it derives the tick from a fixed divider of the clock.

// File: rtl/rx_deferred_pkg.sv
package rx_deferred_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  localparam int STAT_W     = 8;
  localparam int BIT_AVAIL  = 7;
  localparam int BIT_BREAK  = 3;
  localparam int BIT_OVRUN  = 1;
  localparam int BIT_FRAME  = 0;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic avail, input logic brk, input logic ovr, input logic fe);
    logic [STAT_W-1:0] s;
    s = '0;
    s[BIT_AVAIL] = avail;
    s[BIT_BREAK] = brk;
    s[BIT_OVRUN] = ovr;
    s[BIT_FRAME] = fe;
    return s;
  endfunction

  function automatic logic frame_bad(input logic stop_val);
    return !stop_val;
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= RST_VAL;
        else if (g == 0) chain_q[g] <= d_async;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx_deferred_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 rx_s,
  input  logic                 two_stop,
  output logic                 done,
  output logic [DATA_BITS-1:0] done_data,
  output logic                 done_fe,
  output logic                 done_brk
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  rx_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 armed_q;
  logic                 stop1_q;
  logic                 done_q, fe_q, brk_q;
  logic [DATA_BITS-1:0] data_q;

  // Named internal events
  logic start_seen;
  logic start_check;
  logic bit_centre;
  logic frame_end;
  logic stop_val;

  assign start_seen  = (state_q == ST_IDLE) && armed_q && !rx_s;
  assign start_check = tick && (state_q == ST_START) && (cnt_q == MID_CNT);
  assign bit_centre  = tick && (cnt_q == LAST_CNT);
  assign frame_end   = bit_centre &&
                       (((state_q == ST_STOP1) && !two_stop) || (state_q == ST_STOP2));
  assign stop_val    = (state_q == ST_STOP2) ? stop1_q : rx_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      armed_q <= 1'b0;
      stop1_q <= 1'b1;
      done_q  <= 1'b0;
      fe_q    <= 1'b0;
      brk_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (frame_end) begin
        done_q  <= 1'b1;
        data_q  <= shift_q;
        fe_q    <= frame_bad(stop_val);
        brk_q   <= frame_bad(stop_val) && (shift_q == '0);
        state_q <= ST_IDLE;
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (rx_s) armed_q <= 1'b1;
            else if (start_seen) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (start_check) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              state_q <= rx_s ? ST_IDLE : ST_DATA;
            end else if (tick) cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (bit_centre) begin
              shift_q <= {rx_s, shift_q[DATA_BITS-1:1]};
              cnt_q   <= '0;
              if (idx_q == LAST_IDX) state_q <= ST_STOP1;
              else idx_q <= idx_q + 1'b1;
            end else if (tick) cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP1: begin
            if (bit_centre) begin
              stop1_q <= rx_s;
              cnt_q   <= '0;
              state_q <= ST_STOP2;
            end else if (tick) cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP2: begin
            if (tick) cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done      = done_q;
  assign done_data = data_q;
  assign done_fe   = fe_q;
  assign done_brk  = brk_q;

  // R2: completion is a single-cycle event
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R11: without a return to high the receiver cannot leave idle
  a_r11_rearm: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !armed_q && !rx_s) |=> state_q == ST_IDLE);

  // R11: a break is always also a framing error
  a_r11_brk_is_fe: assert property (@(posedge clk) disable iff (rst)
    (done_q && brk_q) |-> fe_q);

  // R12: a start that is high at its centre is abandoned
  a_r12_false_start: assert property (@(posedge clk) disable iff (rst)
    (start_check && rx_s) |=> (state_q == ST_IDLE && !done_q));
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] done_data,
  input  logic                 done_fe,
  input  logic                 done_brk,
  input  logic                 rd_data,
  input  logic                 rd_stat,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 avail,
  output logic                 fe,
  output logic                 brk,
  output logic                 ovr,
  output logic                 irq
);
  logic [DATA_BITS-1:0] data_q, data_n;
  logic avail_q, avail_n, fe_q, fe_n, brk_q, brk_n, ovr_q, ovr_n;
  logic pend_q, pend_n, pbrk_q, pbrk_n, seen_q, seen_n, irq_q, irq_n;

  // Named events for the checks
  logic promote_ev, clear_ev, plain_rd_ev, load_ev, drop_ev;

  assign promote_ev  = rd_data && !ovr_q && pend_q;
  assign clear_ev    = rd_data && ovr_q && seen_q;
  assign plain_rd_ev = rd_data && !ovr_q && !pend_q;

  always_comb begin
    data_n  = data_q;
    avail_n = avail_q;
    fe_n    = fe_q;
    brk_n   = brk_q;
    ovr_n   = ovr_q;
    pend_n  = pend_q;
    pbrk_n  = pbrk_q;
    seen_n  = seen_q;
    irq_n   = irq_q;
    if (rd_data) irq_n = 1'b0;
    if (promote_ev) begin
      ovr_n  = 1'b1;
      brk_n  = pbrk_q;
      pend_n = 1'b0;
      pbrk_n = 1'b0;
      seen_n = 1'b0;
      irq_n  = 1'b1;
    end else if (clear_ev || plain_rd_ev) begin
      avail_n = 1'b0;
      fe_n    = 1'b0;
      brk_n   = 1'b0;
      ovr_n   = 1'b0;
      seen_n  = 1'b0;
    end
    if (rd_stat && ovr_q) seen_n = 1'b1;
    load_ev = done && !avail_n;
    drop_ev = done && avail_n && !ovr_n;
    if (load_ev) begin
      data_n  = done_data;
      avail_n = 1'b1;
      fe_n    = done_fe;
      brk_n   = done_brk;
      irq_n   = 1'b1;
    end else if (drop_ev) begin
      pend_n = 1'b1;
      pbrk_n = pbrk_q | done_brk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      avail_q <= 1'b0;
      fe_q    <= 1'b0;
      brk_q   <= 1'b0;
      ovr_q   <= 1'b0;
      pend_q  <= 1'b0;
      pbrk_q  <= 1'b0;
      seen_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      data_q  <= data_n;
      avail_q <= avail_n;
      fe_q    <= fe_n;
      brk_q   <= brk_n;
      ovr_q   <= ovr_n;
      pend_q  <= pend_n;
      pbrk_q  <= pbrk_n;
      seen_q  <= seen_n;
      irq_q   <= irq_n;
    end
  end

  assign data_out = data_q;
  assign avail    = avail_q;
  assign fe       = fe_q;
  assign brk      = brk_q;
  assign ovr      = ovr_q;
  assign irq      = irq_q;

  // R6: a completion while a byte is held leaves the data untouched
  a_r6_keep_byte: assert property (@(posedge clk) disable iff (rst)
    (done && avail_q && !rd_data) |=> $stable(data_q));

  // R6: overrun only becomes visible on a data read
  a_r6_hidden: assert property (@(posedge clk) disable iff (rst)
    (!ovr_q && !rd_data) |=> !ovr_q);

  // R7: a read exposing a hidden overrun keeps the byte flagged and the interrupt high
  a_r7_reveal: assert property (@(posedge clk) disable iff (rst)
    promote_ev |=> (ovr_q && avail_q && irq_q && $stable(data_q)));

  // R9: status read then data read clears the error state
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (clear_ev && !done) |=> (!avail_q && !ovr_q && !brk_q && !fe_q && !irq_q));

  // R3: an ordinary read drops the interrupt
  a_r3_irq_drop: assert property (@(posedge clk) disable iff (rst)
    (plain_rd_ev && !done) |=> (!irq_q && !avail_q));

  // R10: a data read without a status read keeps the overrun visible
  a_r10_keep_ovr: assert property (@(posedge clk) disable iff (rst)
    (rd_data && ovr_q && !seen_q && !rd_stat) |=> (ovr_q && avail_q));
endmodule

// File: rtl/rx_deferred_top.sv
module rx_deferred_top
  import rx_deferred_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 os_tick,
  input  logic                 rx_line,
  input  logic                 two_stop,
  input  logic                 rd_data,
  input  logic                 rd_stat,
  output logic [DATA_BITS-1:0] data_out,
  output logic [STAT_W-1:0]    status_out,
  output logic                 irq
);
  logic                 rx_s;
  logic                 done, done_fe, done_brk;
  logic [DATA_BITS-1:0] done_data;
  logic                 avail, fe, brk, ovr;

  rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk(clk), .rst(rst), .d_async(rx_line), .q_sync(rx_s));

  rx_framer #(.DATA_BITS(DATA_BITS), .OSR(OSR)) framer_i (
    .clk(clk), .rst(rst), .tick(os_tick), .rx_s(rx_s), .two_stop(two_stop),
    .done(done), .done_data(done_data), .done_fe(done_fe), .done_brk(done_brk));

  rx_status_regs #(.DATA_BITS(DATA_BITS)) regs_i (
    .clk(clk), .rst(rst), .done(done), .done_data(done_data),
    .done_fe(done_fe), .done_brk(done_brk), .rd_data(rd_data), .rd_stat(rd_stat),
    .data_out(data_out), .avail(avail), .fe(fe), .brk(brk), .ovr(ovr), .irq(irq));

  assign status_out = pack_status(avail, brk, ovr, fe);

  // R1: reset leaves every output cleared
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (status_out == '0 && !irq && data_out == '0));

  // R4: a pending flag without a waiting byte is impossible
  a_r4_flags_need_data: assert property (@(posedge clk) disable iff (rst)
    (fe || brk || ovr) |-> avail);
endmodule

// File: tb/rx_deferred_top_tb_top.sv
module rx_deferred_top_tb_top;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst;
  logic       os_tick;
  logic       rx_line;
  logic       two_stop;
  logic       rd_data;
  logic       rd_stat;
  logic [7:0] data_out;
  logic [7:0] status_out;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_flag = 1'b0;
  int div_cnt = 0;

  // Expected status values: bit7 avail, bit3 break, bit1 overrun, bit0 framing
  localparam logic [7:0] S_AV   = 8'h80;
  localparam logic [7:0] S_FE   = 8'h81;
  localparam logic [7:0] S_OV   = 8'h82;
  localparam logic [7:0] S_BRK  = 8'h89;
  localparam logic [7:0] S_OVBK = 8'h8A;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (div_cnt == TICK_DIV - 1) begin
      div_cnt <= 0;
      os_tick <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1;
      os_tick <= 1'b0;
    end
  end

  rx_deferred_top dut_i (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line),
    .two_stop(two_stop), .rd_data(rd_data), .rd_stat(rd_stat),
    .data_out(data_out), .status_out(status_out), .irq(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    @(negedge clk) rx_line = v;
    repeat (BIT_CLK - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic s1, input logic s2, input bit two);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(s1);
    if (two) drive_bit(s2);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic hold_low(input int nbits);
    for (int i = 0; i < nbits; i++) drive_bit(1'b0);
  endtask

  task automatic read_data(output logic [7:0] v);
    @(negedge clk);
    v = data_out;
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
  endtask

  task automatic read_stat(output logic [7:0] v);
    @(negedge clk);
    v = status_out;
    rd_stat = 1'b1;
    @(negedge clk);
    rd_stat = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 data", data_out, 8'h00);
    check("R1 status", status_out, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    send_frame(8'hA5, 1'b1, 1'b1, 1'b0);
    check("R2 data A5", data_out, 8'hA5);
    check("R2 status", status_out, S_AV);
    check("R2 irq", {7'b0, irq}, 8'h01);
    read_data(v);
    check("R3 read value", v, 8'hA5);
    check("R3 status cleared", status_out, 8'h00);
    check("R3 irq cleared", {7'b0, irq}, 8'h00);
    send_frame(8'h01, 1'b1, 1'b1, 1'b0);
    check("R2 lsb first", data_out, 8'h01);
    read_data(v);
  endtask

  task automatic t_framing();
    logic [7:0] v;
    send_frame(8'h55, 1'b0, 1'b1, 1'b0);
    check("R4 status", status_out, S_FE);
    check("R4 irq", {7'b0, irq}, 8'h01);
    read_data(v);
    check("R4 cleared", status_out, 8'h00);
    check("R4 irq cleared", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_two_stop();
    logic [7:0] v;
    @(negedge clk) two_stop = 1'b1;
    send_frame(8'h96, 1'b1, 1'b0, 1'b1);
    check("R5 data", data_out, 8'h96);
    check("R5 second stop ignored", status_out, S_AV);
    read_data(v);
    send_frame(8'h3C, 1'b0, 1'b1, 1'b1);
    check("R5 first stop checked", status_out, S_FE);
    read_data(v);
    @(negedge clk) two_stop = 1'b0;
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    send_frame(8'h11, 1'b1, 1'b1, 1'b0);
    send_frame(8'h22, 1'b1, 1'b1, 1'b0);
    check("R6 byte kept", data_out, 8'h11);
    check("R6 flags hidden", status_out, S_AV);
    read_data(v);
    check("R6 read value", v, 8'h11);
    check("R7 overrun shown", status_out, S_OV);
    check("R7 irq", {7'b0, irq}, 8'h01);
    check("R7 data unchanged", data_out, 8'h11);
    read_data(v);
    check("R10 overrun kept", status_out, S_OV);
    read_stat(v);
    check("R9 status seen", v, S_OV);
    read_data(v);
    check("R9 cleared", status_out, 8'h00);
    check("R9 irq cleared", {7'b0, irq}, 8'h00);
    check("R9 data held", data_out, 8'h11);
    send_frame(8'h33, 1'b1, 1'b1, 1'b0);
    check("R9 next char loads", data_out, 8'h33);
    read_data(v);
  endtask

  task automatic t_break_overrun();
    logic [7:0] v;
    send_frame(8'h44, 1'b1, 1'b1, 1'b0);
    hold_low(10);
    drive_bit(1'b1);
    drive_bit(1'b1);
    check("R8 hidden", status_out, S_AV);
    read_data(v);
    check("R8 break with overrun", status_out, S_OVBK);
    check("R8 data", data_out, 8'h44);
    read_stat(v);
    read_data(v);
    check("R8 cleared", status_out, 8'h00);
  endtask

  task automatic t_break();
    logic [7:0] v;
    hold_low(20);
    check("R11 break status", status_out, S_BRK);
    check("R11 break data", data_out, 8'h00);
    check("R11 irq", {7'b0, irq}, 8'h01);
    read_data(v);
    hold_low(4);
    check("R11 no restart while low", status_out, 8'h00);
    drive_bit(1'b1);
    drive_bit(1'b1);
    check("R11 idle after release", status_out, 8'h00);
  endtask

  task automatic t_glitch();
    @(negedge clk) rx_line = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rx_line = 1'b1;
    repeat (12 * BIT_CLK) @(negedge clk);
    check("R12 no char", status_out, 8'h00);
    check("R12 irq low", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    rst = 1'b1; os_tick = 1'b0; rx_line = 1'b1; two_stop = 1'b0;
    rd_data = 1'b0; rd_stat = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_framing();
    t_two_stop();
    t_overrun();
    t_break_overrun();
    t_break();
    t_glitch();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule